// File: doc/BRIEF.md
# Watchdog Counter with Two-Step Refresh

This block guards a microcontroller against runaway software. A 15-bit counter climbs on every enabled tick of its clock enable. If software does not refresh it in time, the counter rolls over from all ones and the block drives a one-cycle reset pulse that asks the system reset controller to restart the chip.

Software tunes the timeout through an 8-bit configuration register. Bit 7 inserts a divide-by-16 prescaler ahead of the counter. Bits 6..0 give the value that becomes the counter's upper seven bits whenever the counter is reloaded. The register can be written and read back at any moment, whatever the counter is doing.

A refresh takes two separate strobes on back-to-back cycles, an arm strobe and then a fire strobe. A single stray write therefore cannot keep a crashed program alive.

Top module: `wdt_guard`

## Requirements
- R1: After system reset, reg_rdata reads 0x00, wdt_reset is low, the counter starts at zero and the prescaler is off. With tick_en held high, the first wdt_reset pulse is seen 32768 cycles after reset is released.
- R2: A write on reg_wr stores reg_wdata, and reg_rdata shows that value from the next cycle on. Writes are accepted in any cycle, whether or not the counter is running, refreshing or expiring.
- R3: A refresh happens when fire_strobe is high in the cycle that immediately follows a cycle with arm_strobe high. It loads the counter with bits 6..0 of the register in bits 14..8 and zeros in bits 7..0, and it clears the prescaler.
- R4: A fire_strobe that does not directly follow an arm_strobe cycle has no effect. An arm that is not followed at once by a fire is discarded.
- R5: The counter changes only on cycles with tick_en high, or on a refresh or reload. A cycle with tick_en low and no refresh leaves it unchanged.
- R6: When register bit 7 is 1, the counter advances once per 16 enabled ticks. From a refresh with value V, expiry comes after (32768 - 256*V)*16 ticks.
- R7: When an advance finds the counter at 0x7FFF, wdt_reset is high for exactly one cycle (the cycle after that clock edge) and the counter reloads as in R3. With bit 7 at 0, expiry after a refresh with value V comes after 32768 - 256*V ticks.
- R8: If a refresh and a rollover would happen in the same cycle, the refresh wins and no wdt_reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick_en | input | 1 | Clock enable for the watchdog time base |
| reg_wr | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 8 | Write data: bit 7 prescaler select, bits 6..0 reload value |
| reg_rdata | output | 8 | Current configuration register contents |
| arm_strobe | input | 1 | First step of the refresh sequence |
| fire_strobe | input | 1 | Second step of the refresh sequence |
| wdt_reset | output | 1 | One-cycle reset request on counter rollover |

## Verification
The assertions check on every cycle that a refresh only happens right after an arm cycle, that a written value lands in the register, that the counter holds still without a tick or refresh, and that every reset pulse lasts one cycle and leaves the counter at the reload value. Only the bench's scenarios can show the real timeout lengths: 32768 ticks from reset, the shortened and prescaled spans after a refresh, a discarded sequence with a gap between arm and fire, and a refresh that lands exactly on a rollover. A cycle-by-cycle reference model in the bench follows long random mixes of writes, strobes and tick gaps.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int WDT_REG_W = 8;
  parameter int WDT_CNT_W = 15;
  parameter int WDT_PRE_W = 4;

  // Bit 7 selects the prescaler, bits 6..0 are the reload value
  function automatic logic cfg_presc(input logic [WDT_REG_W-1:0] r);
    return r[WDT_REG_W-1];
  endfunction

  function automatic logic [WDT_REG_W-2:0] cfg_reload(input logic [WDT_REG_W-1:0] r);
    return r[WDT_REG_W-2:0];
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
endmodule

// File: rtl/wdt_refresh_seq.sv
module wdt_refresh_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic fire,
  output logic refresh_go
);
  logic armed_q;

  // armed_q lives for exactly one cycle after an arm strobe
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= arm;
  end

  assign refresh_go = fire && armed_q;

  // R3
  refresh_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_go |-> $past(arm));

  // R4
  lone_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !$past(arm)) |-> !refresh_go);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic sel,
  input  logic clr,
  output logic adv
);
  logic [PRE_W-1:0] pre_q;

  assign adv = tick_en && (!sel || (&pre_q));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)      pre_q <= '0;
    else if (tick_en && sel) pre_q <= pre_q + 1'b1;
  end

  // R5
  no_tick_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !adv);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 15,
  parameter int REL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             refresh,
  input  logic [REL_W-1:0] rel_val,
  output logic             wrap,
  output logic             expire_q
);
  localparam int LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {rel_val, {LOW_W{1'b0}}};
  assign wrap     = adv && (&cnt_q) && !refresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= wrap;
      if (refresh || wrap) cnt_q <= load_val;
      else if (adv)        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> cnt_q == {$past(rel_val), {LOW_W{1'b0}}});

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !refresh) |=> $stable(cnt_q));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);

  // R7
  pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> cnt_q == {$past(rel_val), {LOW_W{1'b0}}});

  // R8
  refresh_beats_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !expire_q);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int REG_W = wdt_pkg::WDT_REG_W,
  parameter int CNT_W = wdt_pkg::WDT_CNT_W,
  parameter int PRE_W = wdt_pkg::WDT_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             arm_strobe,
  input  logic             fire_strobe,
  output logic             wdt_reset
);
  localparam int REL_W = REG_W - 1;

  logic [REG_W-1:0] cfg_q;
  logic             refresh_go;
  logic             adv;
  logic             wrap;

  wdt_cfg_reg #(.W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .q(cfg_q)
  );

  wdt_refresh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm_strobe), .fire(fire_strobe),
    .refresh_go(refresh_go)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .sel(cfg_q[REG_W-1]), .clr(refresh_go), .adv(adv)
  );

  wdt_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .refresh(refresh_go),
    .rel_val(cfg_q[REL_W-1:0]), .wrap(wrap), .expire_q(wdt_reset)
  );

  assign reg_rdata = cfg_q;

  // R7
  wrap_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> wdt_reset);
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, reg_wr = 1'b0, arm_strobe = 1'b0, fire_strobe = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wdt_reset;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // reference state
  logic [7:0]  m_reg = 8'h00;
  logic        m_armed = 1'b0;
  logic [3:0]  m_pre = 4'h0;
  logic [14:0] m_cnt = 15'h0;
  logic        m_pulse = 1'b0;

  wdt_guard dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arm_strobe(arm_strobe),
    .fire_strobe(fire_strobe), .wdt_reset(wdt_reset)
  );

  always #10 clk = ~clk;

  function automatic int span(input logic [7:0] r);
    int base = 32768 - 256 * int'(r[6:0]);
    return r[7] ? base * 16 : base;
  endfunction

  function automatic logic [14:0] start_of(input logic [7:0] r);
    return 15'(int'(r[6:0]) * 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // advance the model with the inputs sampled at the last edge
  task automatic model_step();
    logic do_ref, step, roll;
    do_ref = fire_strobe && m_armed;
    step   = tick_en && (!m_reg[7] || m_pre == 4'hF);
    roll   = step && m_cnt == 15'h7FFF && !do_ref;
    m_pulse = roll;
    if (do_ref || roll)  m_cnt = start_of(m_reg);
    else if (step)       m_cnt = m_cnt + 15'd1;
    if (do_ref)                   m_pre = 4'h0;
    else if (tick_en && m_reg[7]) m_pre = m_pre + 4'd1;
    m_armed = arm_strobe;
    if (reg_wr) m_reg = reg_wdata;
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    model_step();
    chk({tag, " pulse"}, int'(wdt_reset), int'(m_pulse));
    chk({tag, " rdata"}, int'(reg_rdata), int'(m_reg));
  endtask

  task automatic idle();
    tick_en = 0; reg_wr = 0; arm_strobe = 0; fire_strobe = 0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    idle(); reg_wr = 1; reg_wdata = v; cyc();
    reg_wr = 0; cyc();
    chk("R2 readback", int'(reg_rdata), int'(v));
  endtask

  task automatic refresh();
    idle(); arm_strobe = 1; cyc();
    arm_strobe = 0; fire_strobe = 1; cyc();
    fire_strobe = 0;
  endtask

  // run n ticks, expect the pulse exactly after the last one
  task automatic expire_in(input int n, input string req);
    int seen_early = 0;
    idle(); tick_en = 1;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (i < n - 1 && wdt_reset) seen_early++;
    end
    chk({req, " no early pulse"}, seen_early, 0);
    chk({req, " pulse at end of span"}, int'(wdt_reset), 1);
    tick_en = 0; cyc();
    chk("R7 pulse is one cycle", int'(wdt_reset), 0);
  endtask

  always @(posedge clk) begin
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    process::self().srandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", int'(reg_rdata), 0);
    chk("R1 pulse in reset", int'(wdt_reset), 0);
    rst_n = 1;

    // R1 / R7: full span from reset
    tag = "R1";
    expire_in(32768, "R1");

    // R2 / R3 / R7: short span after refresh
    tag = "R3";
    write_cfg(8'h7F);
    refresh();
    expire_in(span(8'h7F), "R3");

    // R4: arm, gap, fire is discarded; counter keeps running
    tag = "R4";
    idle(); tick_en = 1;
    repeat (100) cyc();
    idle(); arm_strobe = 1; cyc();
    arm_strobe = 0; cyc();
    fire_strobe = 1; cyc();
    fire_strobe = 0; cyc();
    expire_in(span(8'h7F) - 100, "R4");

    // R4: lone fire ignored
    idle(); tick_en = 1;
    repeat (50) cyc();
    idle(); fire_strobe = 1; cyc();
    expire_in(span(8'h7F) - 50, "R4");

    // R5: no ticks, no pulse even for a long time
    tag = "R5";
    idle(); tick_en = 1; repeat (255) cyc();
    idle(); repeat (300) cyc();
    chk("R5 held without ticks", int'(wdt_reset), 0);
    expire_in(1, "R5");

    // R6: prescaler
    tag = "R6";
    write_cfg(8'hFF);
    refresh();
    expire_in(span(8'hFF), "R6");
    write_cfg(8'hFE);
    refresh();
    expire_in(span(8'hFE), "R6");

    // R8: refresh lands on the rollover tick
    tag = "R8";
    write_cfg(8'h7F);
    refresh();
    idle(); tick_en = 1; repeat (255) cyc();
    idle(); arm_strobe = 1; cyc();
    arm_strobe = 0; fire_strobe = 1; tick_en = 1; cyc();
    chk("R8 refresh wins over rollover", int'(wdt_reset), 0);
    expire_in(span(8'h7F), "R8");

    // random mix checked cycle by cycle
    tag = "R2-mix";
    for (int i = 0; i < 30000; i++) begin
      tick_en     = ($urandom % 4) != 0;
      arm_strobe  = ($urandom % 6) == 0;
      fire_strobe = ($urandom % 3) == 0;
      reg_wr      = ($urandom % 200) == 0;
      reg_wdata   = 8'($urandom) | 8'h70;
      cyc();
    end
    idle(); cyc();
    summary();
  end
endmodule